// File: doc/BRIEF.md
# Home Directory Coherence Engine

This block is the home side of a directory-based coherence scheme for a shared-memory machine with a parameterised number of processors. For every block that lives at this node it keeps a coherence state and a full bit vector of sharers, one bit per processor. It also keeps the block's backing data in a small local store. Caches send it read misses, write misses and write-backs. It answers with data replies, invalidate messages, and fetch requests that go to the current owner. A fetch can either keep the owner's copy or kill it.

A block is in one of three states. In Uncached, no cache holds a copy and the local store is current. In Shared, one or more caches hold read copies and the local store is current. In Exclusive, a single owner holds the only valid copy and the local store is stale. A miss to an Exclusive block makes the engine send a fetch to the owner. The engine then stalls and accepts no further request until the owner's data arrives. That data is written into the local store and forwarded to the requester. Requests are applied strictly in the order they are accepted.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty sharer vector and zero data, `req_ready` is high and no message output is valid.
- R2: A read miss (`req_kind`=0) to an Uncached block replies to the requester with the stored data, and the block becomes Shared with only the requester as sharer.
- R3: A write miss (`req_kind`=1) to an Uncached block replies with the stored data, and the block becomes Exclusive, owned by the requester.
- R4: A read miss to a Shared block replies with the stored data and adds the requester to the sharers. The sharers already present are kept.
- R5: A write miss to a Shared block replies with the stored data in the same cycle as an invalidate. The invalidate's target vector (bit p for processor p) holds every sharer except the requester, and no invalidate is sent if that vector is empty. The block becomes Exclusive, owned by the requester.
- R6: A read miss to an Exclusive block sends a non-destructive fetch (`fch_kill`=0) to the owner. When owner data arrives, the data is written to the store and replied to the requester, and the block becomes Shared with both the owner and the requester.
- R7: A write miss to an Exclusive block sends a destructive fetch (`fch_kill`=1) to the owner. When owner data arrives, the data is written to the store and replied to the requester, and the block stays Exclusive, now owned by the requester.
- R8: A write-back (`req_kind`=2) from the owner of an Exclusive block writes its data into the store, and the block becomes Uncached with no sharers.
- R9: Three kinds of request have no effect and produce no message: a write-back to a block that is not Exclusive, a write-back from a processor that is not the owner, and a request with `req_kind`=3.
- R10: Between a fetch and the owner's data, `req_ready` is low and any offered request is not taken. Owner data offered while no fetch is pending is ignored.
- R11: Every message is a one-cycle pulse. It appears one clock after the request is accepted, or one clock after the owner data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 reserved |
| req_src | input | log2(NUM_PROCS) | Requesting processor number |
| req_addr | input | log2(NUM_BLOCKS) | Block index |
| req_data | input | DATA_W | Write-back data |
| own_valid | input | 1 | Owner data returned after a fetch |
| own_data | input | DATA_W | Owner's block data |
| rsp_valid | output | 1 | Data reply pulse |
| rsp_dest | output | log2(NUM_PROCS) | Reply destination |
| rsp_data | output | DATA_W | Reply data |
| inv_valid | output | 1 | Invalidate pulse |
| inv_targets | output | NUM_PROCS | Processors to invalidate |
| inv_addr | output | log2(NUM_BLOCKS) | Block to invalidate |
| fch_valid | output | 1 | Fetch pulse |
| fch_kill | output | 1 | Fetch also invalidates the owner copy |
| fch_dest | output | log2(NUM_PROCS) | Owner being fetched from |
| fch_addr | output | log2(NUM_BLOCKS) | Block being fetched |

## Verification
The assertions assume that owner data arrives only as a single pulse answering an outstanding fetch. They also assume a caller that offers a request with all fields stable for the cycle it is taken. The stimulus always returns exactly one owner pulse after each fetch. It also deliberately sends a stray owner pulse while idle, and a request during the wait, to confirm both are ignored. Because a write miss in Shared could otherwise name the requester itself, the assertions rely on the engine never invalidating the processor it is replying to.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    BLK_UNC = 2'd0,
    BLK_SHR = 2'd1,
    BLK_EXC = 2'd2
  } blk_state_e;

  typedef enum logic [1:0] {
    K_RD  = 2'd0,
    K_WR  = 2'd1,
    K_WB  = 2'd2,
    K_RSV = 2'd3
  } req_kind_e;

  typedef enum logic {
    M_IDLE = 1'b0,
    M_WAIT = 1'b1
  } ctl_mode_e;

endpackage

// File: rtl/dir_entry_table.sv
module dir_entry_table
  import dir_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int NUM_PROCS  = 4,
  localparam int ADDR_W    = $clog2(NUM_BLOCKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    rd_idx,
  output blk_state_e           rd_state,
  output logic [NUM_PROCS-1:0] rd_sharers,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_idx,
  input  blk_state_e           wr_state,
  input  logic [NUM_PROCS-1:0] wr_sharers
);

  blk_state_e           st_q [NUM_BLOCKS];
  logic [NUM_PROCS-1:0] sh_q [NUM_BLOCKS];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == ADDR_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[b] <= BLK_UNC;
        sh_q[b] <= '0;
      end else if (hit) begin
        st_q[b] <= wr_state;
        sh_q[b] <= wr_sharers;
      end
    end
  end

  assign rd_state   = st_q[rd_idx];
  assign rd_sharers = sh_q[rd_idx];

endmodule

// File: rtl/dir_data_store.sv
module dir_data_store #(
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int ADDR_W    = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem_q [NUM_BLOCKS];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_idx == ADDR_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[b] <= '0;
      end else if (hit) begin
        mem_q[b] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dir_pkg::*;
#(
  parameter int NUM_PROCS = 4,
  parameter int DATA_W    = 16,
  localparam int PROC_W   = $clog2(NUM_PROCS)
) (
  input  ctl_mode_e            mode,
  input  logic                 req_valid,
  input  logic [1:0]           req_kind,
  input  logic [PROC_W-1:0]    req_src,
  input  logic [DATA_W-1:0]    req_data,
  input  logic                 own_valid,
  input  logic [DATA_W-1:0]    own_data,
  input  logic [1:0]           pend_kind,
  input  logic [PROC_W-1:0]    pend_src,
  input  blk_state_e           ent_state,
  input  logic [NUM_PROCS-1:0] ent_sharers,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 ent_we,
  output blk_state_e           ent_state_n,
  output logic [NUM_PROCS-1:0] ent_sharers_n,
  output logic                 mem_we,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic                 rsp_fire,
  output logic [PROC_W-1:0]    rsp_dest_n,
  output logic [DATA_W-1:0]    rsp_data_n,
  output logic                 inv_fire,
  output logic [NUM_PROCS-1:0] inv_mask_n,
  output logic                 fch_fire,
  output logic                 fch_kill_n,
  output logic [PROC_W-1:0]    fch_dest_n,
  output logic                 pend_load,
  output ctl_mode_e            mode_n
);

  logic [NUM_PROCS-1:0] src_bit;
  logic [NUM_PROCS-1:0] pend_bit;
  logic [NUM_PROCS-1:0] others;
  logic [PROC_W-1:0]    owner_idx;

  assign src_bit  = NUM_PROCS'(1) << req_src;
  assign pend_bit = NUM_PROCS'(1) << pend_src;
  assign others   = ent_sharers & ~src_bit;

  always_comb begin
    owner_idx = '0;
    for (int p = 0; p < NUM_PROCS; p++) begin
      if (ent_sharers[p]) owner_idx = PROC_W'(p);
    end
  end

  always_comb begin
    ent_we        = 1'b0;
    ent_state_n   = ent_state;
    ent_sharers_n = ent_sharers;
    mem_we        = 1'b0;
    mem_wdata     = req_data;
    rsp_fire      = 1'b0;
    rsp_dest_n    = req_src;
    rsp_data_n    = mem_rdata;
    inv_fire      = 1'b0;
    inv_mask_n    = '0;
    fch_fire      = 1'b0;
    fch_kill_n    = 1'b0;
    fch_dest_n    = owner_idx;
    pend_load     = 1'b0;
    mode_n        = mode;

    if (mode == M_IDLE && req_valid) begin
      unique case (req_kind)
        K_RD: begin
          unique case (ent_state)
            BLK_UNC: begin
              rsp_fire      = 1'b1;
              ent_we        = 1'b1;
              ent_state_n   = BLK_SHR;
              ent_sharers_n = src_bit;
            end
            BLK_SHR: begin
              rsp_fire      = 1'b1;
              ent_we        = 1'b1;
              ent_sharers_n = ent_sharers | src_bit;
            end
            BLK_EXC: begin
              fch_fire  = 1'b1;
              pend_load = 1'b1;
              mode_n    = M_WAIT;
            end
            default: ;
          endcase
        end
        K_WR: begin
          unique case (ent_state)
            BLK_UNC, BLK_SHR: begin
              rsp_fire      = 1'b1;
              inv_fire      = (ent_state == BLK_SHR) && (|others);
              inv_mask_n    = others;
              ent_we        = 1'b1;
              ent_state_n   = BLK_EXC;
              ent_sharers_n = src_bit;
            end
            BLK_EXC: begin
              fch_fire   = 1'b1;
              fch_kill_n = 1'b1;
              pend_load  = 1'b1;
              mode_n     = M_WAIT;
            end
            default: ;
          endcase
        end
        K_WB: begin
          if (ent_state == BLK_EXC && ent_sharers == src_bit) begin
            mem_we        = 1'b1;
            ent_we        = 1'b1;
            ent_state_n   = BLK_UNC;
            ent_sharers_n = '0;
          end
        end
        default: ;
      endcase
    end else if (mode == M_WAIT && own_valid) begin
      rsp_fire   = 1'b1;
      rsp_dest_n = pend_src;
      rsp_data_n = own_data;
      mem_we     = 1'b1;
      mem_wdata  = own_data;
      ent_we     = 1'b1;
      if (pend_kind == K_RD) begin
        ent_state_n   = BLK_SHR;
        ent_sharers_n = ent_sharers | pend_bit;
      end else begin
        ent_state_n   = BLK_EXC;
        ent_sharers_n = pend_bit;
      end
      mode_n = M_IDLE;
    end
  end

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int PROC_W    = $clog2(NUM_PROCS),
  localparam int ADDR_W    = $clog2(NUM_BLOCKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_kind,
  input  logic [PROC_W-1:0]    req_src,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_data,
  input  logic                 own_valid,
  input  logic [DATA_W-1:0]    own_data,
  output logic                 rsp_valid,
  output logic [PROC_W-1:0]    rsp_dest,
  output logic [DATA_W-1:0]    rsp_data,
  output logic                 inv_valid,
  output logic [NUM_PROCS-1:0] inv_targets,
  output logic [ADDR_W-1:0]    inv_addr,
  output logic                 fch_valid,
  output logic                 fch_kill,
  output logic [PROC_W-1:0]    fch_dest,
  output logic [ADDR_W-1:0]    fch_addr
);

  ctl_mode_e          mode_q, mode_n;
  logic [1:0]         pend_kind_q;
  logic [PROC_W-1:0]  pend_src_q;
  logic [ADDR_W-1:0]  pend_addr_q;

  logic [ADDR_W-1:0]    idx;
  blk_state_e           ent_state, ent_state_n;
  logic [NUM_PROCS-1:0] ent_sharers, ent_sharers_n;
  logic                 ent_we, mem_we, pend_load;
  logic [DATA_W-1:0]    mem_rdata, mem_wdata;
  logic                 rsp_fire, inv_fire, fch_fire, fch_kill_n;
  logic [PROC_W-1:0]    rsp_dest_n, fch_dest_n;
  logic [DATA_W-1:0]    rsp_data_n;
  logic [NUM_PROCS-1:0] inv_mask_n;

  assign idx       = (mode_q == M_WAIT) ? pend_addr_q : req_addr;
  assign req_ready = (mode_q == M_IDLE);

  dir_entry_table #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .NUM_PROCS (NUM_PROCS)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (idx),
    .rd_state  (ent_state),
    .rd_sharers(ent_sharers),
    .wr_en     (ent_we),
    .wr_idx    (idx),
    .wr_state  (ent_state_n),
    .wr_sharers(ent_sharers_n)
  );

  dir_data_store #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .DATA_W    (DATA_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (idx),
    .rd_data(mem_rdata),
    .wr_en  (mem_we),
    .wr_idx (idx),
    .wr_data(mem_wdata)
  );

  dir_decide #(
    .NUM_PROCS(NUM_PROCS),
    .DATA_W   (DATA_W)
  ) u_decide (
    .mode         (mode_q),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_src      (req_src),
    .req_data     (req_data),
    .own_valid    (own_valid),
    .own_data     (own_data),
    .pend_kind    (pend_kind_q),
    .pend_src     (pend_src_q),
    .ent_state    (ent_state),
    .ent_sharers  (ent_sharers),
    .mem_rdata    (mem_rdata),
    .ent_we       (ent_we),
    .ent_state_n  (ent_state_n),
    .ent_sharers_n(ent_sharers_n),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .rsp_fire     (rsp_fire),
    .rsp_dest_n   (rsp_dest_n),
    .rsp_data_n   (rsp_data_n),
    .inv_fire     (inv_fire),
    .inv_mask_n   (inv_mask_n),
    .fch_fire     (fch_fire),
    .fch_kill_n   (fch_kill_n),
    .fch_dest_n   (fch_dest_n),
    .pend_load    (pend_load),
    .mode_n       (mode_n)
  );

  // Mode and pending request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_IDLE;
      pend_kind_q <= '0;
      pend_src_q  <= '0;
      pend_addr_q <= '0;
    end else begin
      mode_q <= mode_n;
      if (pend_load) begin
        pend_kind_q <= req_kind;
        pend_src_q  <= req_src;
        pend_addr_q <= req_addr;
      end
    end
  end

  // Registered message outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_dest    <= '0;
      rsp_data    <= '0;
      inv_valid   <= 1'b0;
      inv_targets <= '0;
      inv_addr    <= '0;
      fch_valid   <= 1'b0;
      fch_kill    <= 1'b0;
      fch_dest    <= '0;
      fch_addr    <= '0;
    end else begin
      rsp_valid <= rsp_fire;
      inv_valid <= inv_fire;
      fch_valid <= fch_fire;
      if (rsp_fire) begin
        rsp_dest <= rsp_dest_n;
        rsp_data <= rsp_data_n;
      end
      if (inv_fire) begin
        inv_targets <= inv_mask_n;
        inv_addr    <= idx;
      end
      if (fch_fire) begin
        fch_kill <= fch_kill_n;
        fch_dest <= fch_dest_n;
        fch_addr <= idx;
      end
    end
  end

endmodule

// File: rtl/home_dir_ctrl_chk.sv
module home_dir_ctrl_chk #(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  localparam int PROC_W    = $clog2(NUM_PROCS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [1:0]           req_kind,
  input logic                 own_valid,
  input logic                 rsp_valid,
  input logic [PROC_W-1:0]    rsp_dest,
  input logic                 inv_valid,
  input logic [NUM_PROCS-1:0] inv_targets,
  input logic                 fch_valid
);

  // R10: a fetch leaves the engine stalled
  a_r10_stall_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fch_valid |-> !req_ready);

  // R10: owner data during a stall releases it with a reply
  a_r10_release_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && own_valid) |=> (rsp_valid && req_ready));

  // R5: invalidates ride with a reply and never hit the requester
  a_r5_inv_spares_dest: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (rsp_valid && !inv_targets[rsp_dest]));

  // R11: a reply and a fetch never share a cycle
  a_r11_rsp_or_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && fch_valid));

  // R9: an accepted write-back or reserved request emits nothing
  a_r9_wb_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind[1]) |=> (!rsp_valid && !inv_valid && !fch_valid));

  // R10: a request offered while stalled produces no reply next cycle
  a_r10_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !own_valid) |=> !rsp_valid);

endmodule

bind home_dir_ctrl home_dir_ctrl_chk #(
  .NUM_PROCS (NUM_PROCS),
  .NUM_BLOCKS(NUM_BLOCKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_kind   (req_kind),
  .own_valid  (own_valid),
  .rsp_valid  (rsp_valid),
  .rsp_dest   (rsp_dest),
  .inv_valid  (inv_valid),
  .inv_targets(inv_targets),
  .fch_valid  (fch_valid)
);

// File: tb/home_dir_ctrl_tb.sv
`timescale 1ns/1ps
module home_dir_ctrl_tb;

  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;
  localparam int PW = $clog2(NP);
  localparam int AW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_kind;
  logic [PW-1:0] req_src;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          own_valid;
  logic [DW-1:0] own_data;
  logic          rsp_valid;
  logic [PW-1:0] rsp_dest;
  logic [DW-1:0] rsp_data;
  logic          inv_valid;
  logic [NP-1:0] inv_targets;
  logic [AW-1:0] inv_addr;
  logic          fch_valid;
  logic          fch_kill;
  logic [PW-1:0] fch_dest;
  logic [AW-1:0] fch_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  home_dir_ctrl #(.NUM_PROCS(NP), .NUM_BLOCKS(NB), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
    .own_valid(own_valid), .own_data(own_data),
    .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_data(rsp_data),
    .inv_valid(inv_valid), .inv_targets(inv_targets), .inv_addr(inv_addr),
    .fch_valid(fch_valid), .fch_kill(fch_kill), .fch_dest(fch_dest), .fch_addr(fch_addr)
  );

  // ---------------- behavioural reference ----------------
  int      m_state [NB];   // 0 none, 1 readers, 2 owned
  bit [NP-1:0] m_sh [NB];
  int      m_mem [NB];
  bit      m_wait;
  int      p_kind, p_src, p_addr;
  bit      e_rsp, e_inv, e_fch, e_kill;
  int      e_dest, e_data, e_fdest, e_addr;
  bit [NP-1:0] e_mask;
  string   tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin m_state[b] = 0; m_sh[b] = '0; m_mem[b] = 0; end
      m_wait = 0; e_rsp = 0; e_inv = 0; e_fch = 0; tag = "R1";
    end else begin
      e_rsp = 0; e_inv = 0; e_fch = 0; tag = "R11";
      if (!m_wait && req_valid) begin
        int a, s, own;
        a = req_addr; s = req_src; own = 0;
        for (int p = 0; p < NP; p++) if (m_sh[a][p]) own = p;
        if (req_kind == 0) begin
          if (m_state[a] == 2) begin
            e_fch = 1; e_kill = 0; e_fdest = own; e_addr = a;
            m_wait = 1; p_kind = 0; p_src = s; p_addr = a; tag = "R6";
          end else begin
            e_rsp = 1; e_dest = s; e_data = m_mem[a];
            tag = (m_state[a] == 0) ? "R2" : "R4";
            if (m_state[a] == 0) m_sh[a] = '0;
            m_sh[a][s] = 1'b1; m_state[a] = 1;
          end
        end else if (req_kind == 1) begin
          if (m_state[a] == 2) begin
            e_fch = 1; e_kill = 1; e_fdest = own; e_addr = a;
            m_wait = 1; p_kind = 1; p_src = s; p_addr = a; tag = "R7";
          end else begin
            e_rsp = 1; e_dest = s; e_data = m_mem[a];
            tag = (m_state[a] == 0) ? "R3" : "R5";
            if (m_state[a] == 1) begin
              e_mask = m_sh[a]; e_mask[s] = 1'b0;
              e_inv = (e_mask != 0); e_addr = a;
            end
            m_sh[a] = '0; m_sh[a][s] = 1'b1; m_state[a] = 2;
          end
        end else if (req_kind == 2 && m_state[a] == 2 && m_sh[a][s] && $countones(m_sh[a]) == 1) begin
          m_mem[a] = req_data; m_state[a] = 0; m_sh[a] = '0; tag = "R8";
        end else begin
          tag = "R9";
        end
      end else if (m_wait && own_valid) begin
        e_rsp = 1; e_dest = p_src; e_data = own_data;
        m_mem[p_addr] = own_data; m_wait = 0;
        if (p_kind == 0) begin m_sh[p_addr][p_src] = 1'b1; m_state[p_addr] = 1; tag = "R6"; end
        else begin m_sh[p_addr] = '0; m_sh[p_addr][p_src] = 1'b1; m_state[p_addr] = 2; tag = "R7"; end
      end else if (req_valid || own_valid) begin
        tag = "R10";
      end
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, "ready", int'(req_ready), int'(!m_wait));
      check(tag, "rsp_valid", int'(rsp_valid), int'(e_rsp));
      if (e_rsp) begin
        check(tag, "rsp_dest", int'(rsp_dest), e_dest);
        check(tag, "rsp_data", int'(rsp_data), e_data);
      end
      check(tag, "inv_valid", int'(inv_valid), int'(e_inv));
      if (e_inv) begin
        check(tag, "inv_targets", int'(inv_targets), int'(e_mask));
        check(tag, "inv_addr", int'(inv_addr), e_addr);
      end
      check(tag, "fch_valid", int'(fch_valid), int'(e_fch));
      if (e_fch) begin
        check(tag, "fch_kill", int'(fch_kill), int'(e_kill));
        check(tag, "fch_dest", int'(fch_dest), e_fdest);
        check(tag, "fch_addr", int'(fch_addr), e_addr);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input int k, input int s, input int a, input int d);
    req_valid = 1'b1; req_kind = 2'(k); req_src = PW'(s); req_addr = AW'(a); req_data = DW'(d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic give(input int d);
    own_valid = 1'b1; own_data = DW'(d);
    @(negedge clk);
    own_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_src = '0; req_addr = '0;
    req_data = '0; own_valid = 1'b0; own_data = '0;
    idle(3);
    // R1: reset state at the ports
    check("R1", "ready", int'(req_ready), 1);
    check("R1", "no msg", int'(rsp_valid | inv_valid | fch_valid), 0);
    rst_n = 1'b1;
    idle(1);
    send(0, 0, 1, 0);        // R2 uncached read, data zero
    send(0, 1, 1, 0);        // R4
    send(0, 2, 1, 0);        // R4
    send(1, 1, 1, 0);        // R5 invalidate p0,p2
    send(2, 0, 1, 16'h55);   // R9 write-back from non-owner
    send(0, 3, 1, 0);        // R6 fetch owner p1
    send(0, 0, 2, 0);        // R10 offered during wait
    idle(1);
    give(16'h1234);          // R6 completion
    send(0, 0, 1, 0);        // R4 sees 1234
    send(1, 0, 1, 0);        // R5 invalidate p1,p3
    send(1, 2, 1, 0);        // R7 destructive fetch from p0
    idle(2);
    give(16'hBEEF);          // R7 completion
    send(2, 2, 1, 16'h7777); // R8
    send(0, 3, 1, 0);        // R2 reads 7777
    send(1, 1, 3, 0);        // R3
    send(2, 1, 3, 16'h9);    // R8
    give(16'hDEAD);          // R10 stray owner data ignored
    send(3, 0, 3, 0);        // R9 reserved kind
    send(1, 1, 3, 0);        // R3 reply 9
    send(2, 2, 5, 16'hAA);   // R9 write-back to uncached
    send(0, 2, 5, 0);        // R2 still zero
    send(0, 0, 6, 0);        // R2
    send(1, 0, 6, 0);        // R5 only requester: no invalidate
    send(1, 3, 6, 0);        // R7 fetch kill from p0
    give(16'h4242);
    send(0, 1, 6, 0);        // R6 fetch from p3
    give(16'h0F0F);
    send(1, 1, 6, 0);        // R5 invalidate p3
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R11 watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule